// File: doc/BRIEF.md
# Interval Timer with Selectable Prescaler

This block is an 8-bit down-counter with a prescaler, used as the interval timer in an I/O companion device next to a small CPU. The CPU writes a start count. The address of that write picks how many system clocks pass between decrements (1, 8, 64 or 1024) and whether the interrupt pin is armed. The counter then runs down at the chosen rate, and the CPU polls either the count or a status byte.

When the count passes zero it wraps to 0xFF, raises an underflow flag and drops to one decrement per clock. The programmed prescaler keeps running in the background. A later read of the count returns the timer to its programmed rate without reloading the count. The next slow decrement then lands on the next expiry of that free-running prescaler, counted from the last write, and not one full period after the read.

Because the one-per-clock phase is exact, a polling loop whose period shares a factor with 256 can step over zero forever. The block reproduces that timing cycle for cycle.

Top module: `ivt_timer`

## Requirements
- R1: A write stores `wdata` as the count. Address bits [1:0] pick the divide ratio: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 1024. Address bit 2 arms the interrupt output. The write also clears the underflow flag, leaves the one-per-clock mode and restarts the prescaler, so the first decrement lands on the edge R clocks after the write edge, where R is the ratio.
- R2: Before an underflow, the count drops by one on every R-th edge after the write edge, and on no other edge.
- R3: A decrement taken while the count is 0x00 gives 0xFF, sets the underflow flag and enters the one-per-clock mode.
- R4: In the one-per-clock mode the count drops by one on every edge. With no count read it keeps wrapping past 0x00, whatever ratio is programmed.
- R5: A read with address bit 0 low returns the current count on `rdata`. If the one-per-clock mode is active, that read ends it. The count is not reloaded, and the read edge itself still takes its one-per-clock decrement.
- R6: After a count read ends the one-per-clock mode, the next decrement lands on the next edge that is a whole multiple of R edges after the last write edge.
- R7: A read with address bit 0 high returns the status byte: bit 6 holds the underflow flag and every other bit reads 0. A status read leaves the flag, the mode and the count unchanged. A count read clears the flag.
- R8: `irq_n` is low exactly while the underflow flag is set and the interrupt was armed by the last write.
- R9: If a write and an underflow fall on the same edge, the write wins: the count takes `wdata`, and the flag and the one-per-clock mode stay clear.
- R10: If an underflow and a count read fall on the same edge, the underflow wins: the flag ends up set and the one-per-clock mode is active.
- R11: During reset the count is 0x00, the ratio is 1, the flag is clear and the interrupt is disarmed, so `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address: bit 0 picks count or status on reads; bits [1:0] pick the ratio and bit 2 arms the interrupt on writes |
| rd_en | input | 1 | Read strobe, active for one clock per access |
| wr_en | input | 1 | Write strobe, active for one clock per access |
| wdata | input | CNT_W | Start count for a write |
| rdata | output | CNT_W | Count or status byte, chosen by addr bit 0 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
For every ratio, the counter is loaded with a small value and read on every clock until it underflows. This separates the decrement rate of each ratio and the exact wrap edge. Status-only polling through the one-per-clock phase then confirms that the flag and the fast rate hold without disturbing the count. A count read at several offsets after the wrap shows whether the restored rate follows the free-running prescaler phase or a prescaler restarted by the read. Separate patterns cover a long run of repeated wraps with the interrupt disarmed, a write landing on the underflow edge, and a count read landing on the underflow edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  // Prescaler width covers the largest divide ratio (1024 clocks).
  localparam int PRE_W = 10;

  typedef enum logic [1:0] {
    DIV_1    = 2'b00,
    DIV_8    = 2'b01,
    DIV_64   = 2'b10,
    DIV_1024 = 2'b11
  } div_sel_e;

  // Phase mask: the prescaler expires when all masked bits are ones.
  function automatic logic [PRE_W-1:0] div_mask(div_sel_e sel);
    case (sel)
      DIV_1:   div_mask = PRE_W'(0);
      DIV_8:   div_mask = PRE_W'(7);
      DIV_64:  div_mask = PRE_W'(63);
      default: div_mask = PRE_W'(1023);
    endcase
  endfunction

  function automatic logic div_expired(logic [PRE_W-1:0] phase, div_sel_e sel);
    div_expired = ((phase & div_mask(sel)) == div_mask(sel));
  endfunction

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
  import ivt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  input  div_sel_e sel,
  output logic     tick
);

  logic [PRE_W-1:0] phase_q;

  // Free-running phase; only a write restarts it, never a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  assign tick = div_expired(phase_q, sel);

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             cnt_rd,
  output logic [CNT_W-1:0] count_q,
  output logic             fast_q,
  output logic             flag_q,
  output logic             dec,
  output logic             uf
);

  assign dec = fast_q | tick;
  assign uf  = dec & (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      fast_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else if (load) begin
      count_q <= load_val;
      fast_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (dec) count_q <= count_q - 1'b1;
      if (uf) begin
        fast_q <= 1'b1;
        flag_q <= 1'b1;
      end else if (cnt_rd) begin
        fast_q <= 1'b0;
        flag_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ivt_regif.sv
module ivt_regif
  import ivt_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int STAT_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] count_q,
  input  logic             flag_q,
  output logic             wr_hit,
  output logic             cnt_rd,
  output div_sel_e         sel_q,
  output logic             ie_q,
  output logic [CNT_W-1:0] rdata
);

  logic [CNT_W-1:0] status;

  assign wr_hit = wr_en;
  assign cnt_rd = rd_en & ~addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= DIV_1;
      ie_q  <= 1'b0;
    end else if (wr_hit) begin
      sel_q <= div_sel_e'(addr[1:0]);
      ie_q  <= addr[2];
    end
  end

  always_comb begin
    status           = '0;
    status[STAT_BIT] = flag_q;
    rdata            = addr[0] ? status : count_q;
  end

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq_n
);

  // Named internal events, visible to the bound checker.
  logic             wr_hit;
  logic             cnt_rd;
  logic             tick;
  logic             dec;
  logic             uf;
  logic             fast_q;
  logic             flag_q;
  logic             ie_q;
  logic [CNT_W-1:0] count_q;
  div_sel_e         sel_q;

  ivt_regif #(.CNT_W(CNT_W), .STAT_BIT(6)) regif_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr[2:0]),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .count_q (count_q),
    .flag_q  (flag_q),
    .wr_hit  (wr_hit),
    .cnt_rd  (cnt_rd),
    .sel_q   (sel_q),
    .ie_q    (ie_q),
    .rdata   (rdata)
  );

  ivt_prescaler presc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_hit),
    .sel     (sel_q),
    .tick    (tick)
  );

  ivt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_hit),
    .load_val (wdata),
    .tick     (tick),
    .cnt_rd   (cnt_rd),
    .count_q  (count_q),
    .fast_q   (fast_q),
    .flag_q   (flag_q),
    .dec      (dec),
    .uf       (uf)
  );

  assign irq_n = ~(flag_q & ie_q);

endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_hit,
  input logic             cnt_rd,
  input logic             uf,
  input logic             tick,
  input logic             fast_q,
  input logic             flag_q,
  input logic             ie_q,
  input logic             irq_n,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] wdata
);

  // R1
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (count_q == $past(wdata)) && !flag_q && !fast_q);

  // R3
  wrap_enter_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !wr_hit) |=> flag_q && fast_q && (count_q == '1));

  // R4
  fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_q && !wr_hit) |=> count_q == CNT_W'($past(count_q) - 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_q && !tick && !wr_hit) |=> $stable(count_q));

  // R5
  read_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd && !uf && !wr_hit) |=> !fast_q && !flag_q);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |-> irq_n);

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && ie_q) |-> !irq_n);

endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;

  logic       clk   = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr  = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        irq_n;

  int checks = 0;
  int errors = 0;

  // Reference state, updated once per clock edge from the requirements.
  int m_cnt = 0, m_ph = 0, m_sel = 0, m_fast = 0, m_flag = 0, m_ie = 0;

  always #4 clk = ~clk;

  ivt_timer dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata),
    .irq_n (irq_n)
  );

  function automatic int ratio(int s);
    return (s == 3) ? 1024 : (1 << (3 * s));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One bus cycle: drive at the falling edge, check, then advance the model.
  task automatic step(bit rd, bit wr, int a, int d, string req);
    bit tk, dc, ufl;
    rd_en = rd;
    wr_en = wr;
    addr  = a[2:0];
    wdata = d[7:0];
    #1;
    if (rd) chk(req, int'(rdata), (a % 2 == 1) ? (m_flag << 6) : m_cnt);
    chk("R8", int'(irq_n), (m_flag != 0 && m_ie != 0) ? 0 : 1);
    if (wr) begin
      m_cnt = d; m_sel = a % 4; m_ie = (a / 4) % 2;
      m_ph = 0; m_fast = 0; m_flag = 0;
    end else begin
      tk  = (m_ph % ratio(m_sel)) == ratio(m_sel) - 1;
      dc  = (m_fast != 0) || tk;
      ufl = dc && (m_cnt == 0);
      if (dc) m_cnt = (m_cnt + 255) % 256;
      m_ph = (m_ph + 1) % 1024;
      if (ufl) begin m_fast = 1; m_flag = 1; end
      else if (rd && (a % 2 == 0)) begin m_fast = 0; m_flag = 0; end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  // Load, run to the wrap, poll status for 'off' clocks, then read the count
  // and watch where the restored slow rate lands.
  task automatic ratio_run(int s, int n, int off);
    step(0, 1, 4 + s, n, "R1");
    while (m_fast == 0) step(1, 0, 0, 0, "R2");
    for (int i = 0; i < off; i++) step(1, 0, 1, 0, "R7");
    step(1, 0, 0, 0, "R5");
    for (int i = 0; i < 2 * ratio(s) + 2; i++) step(1, 0, 0, 0, "R6");
    step(1, 0, 1, 0, "R7");
  endtask

  initial begin
    @(negedge clk);
    rd_en = 1'b1; addr = 3'd0;
    #1 chk("R11", int'(rdata), 0);
    chk("R11", int'(irq_n), 1);
    addr = 3'd1;
    #1 chk("R11", int'(rdata), 0);
    rd_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      ratio_run(s, 2, 0);
      ratio_run(s, 3, 1);
      ratio_run(s, 1, 5);
    end

    // R4: disarmed interrupt, long one-per-clock run with repeated wraps.
    step(0, 1, 1, 5, "R1");
    for (int i = 0; i < 700; i++) step(1, 0, 1, 0, "R4");
    step(1, 0, 0, 0, "R4");

    // R9: second write lands on the edge where the count would wrap.
    step(0, 1, 0, 0, "R1");
    step(0, 1, 4, 0, "R9");
    step(1, 0, 1, 0, "R9");

    // R10: count read lands on the wrap edge.
    step(0, 1, 4, 0, "R1");
    step(1, 0, 0, 0, "R10");
    step(1, 0, 1, 0, "R10");
    step(1, 0, 0, 0, "R10");

    step(0, 0, 0, 0, "R8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule